// File: doc/BRIEF.md
# Flash Array Integrity Signature Walker

This block verifies the contents of a flash array by reading every word of a chosen set of blocks and compressing the words into a 160-bit multiple-input signature register (MISR). Software enables a dedicated test mode and picks the blocks with a select mask. It chooses one of two address orders, supplies a seed for the signature and pulses a start request. When the walk finishes, software compares the signature it reads back against a known-good value. Each read carries an ECC-detection flag, and that flag is compressed along with the data. A single bad bit or a single ECC event therefore changes the result.

The block drives a simple memory read port with an enable and an address. The memory returns the data word and its ECC flag one cycle after the enable. Host reads share this port. In sequential order a host read takes the port for that cycle, and the walk picks up at the address it had reached. In the alternating order the host is held off until the walk ends, so the result is deterministic. One block index is reserved for the configuration (shadow) block, and that block is never walked.

Top module: `flash_sig_walker`

## Requirements
- R1: A start request is accepted only when `test_en` is 1 and `busy` is 0. With `test_en` at 0 a start leaves `busy`, `done` and `signature` unchanged.
- R2: Only blocks whose bit is set in `blk_sel` are read, in ascending block index. Each word is read exactly once. The walk address is `mem_addr = {block index, word offset}`, with the offset in the low `BLK_AW` bits.
- R3: The block with index `SHADOW_BLK` (default 3) is never read by the walk, even when its select bit is set.
- R4: With `seq_mode` = 1 the offsets within a block run 0, 1, ..., W-1, where W = 2^BLK_AW.
- R5: With `seq_mode` = 0 the offsets within a block run p, W-1-p for p = 0 .. W/2-1, which is each address followed by its bitwise complement.
- R6: During a sequential walk, a host request takes the port in the same cycle: `host_gnt` = 1, `mem_re` = 1 and `mem_addr` = `host_addr`. The walk then resumes at the address it had not yet issued.
- R7: While an alternating walk is running, `host_gnt` stays 0. When no walk is running, `host_gnt` equals `host_req`.
- R8: An accepted start loads `seed` into `signature` at that clock edge. The signature does not change while the block is idle, and it stays readable after completion.
- R9: Read data returns one cycle after the walk issues `mem_re`. At that edge the signature shifts left by one bit. If the bit shifted out was 1, the constant with bits 159, 158, 157 and 0 set is XORed in. Then `mem_rdata` is XORed into bits 31:0 and `mem_ecc` into bit 32.
- R10: `busy` rises the cycle after an accepted start and falls when the last word is compressed. `done` rises in that same cycle, and `done` and `busy` are never both 1. A start with no walkable block sets `done` the next cycle and leaves `busy` at 0. After reset both flags are 0 and `signature` is 0.
- R11: `seq_mode` and `blk_sel` are sampled at the accepted start. Changing them while busy has no effect on the walk.
- R12: A start request while busy is ignored, and the seed is not reloaded.
- R13: Driving `test_en` to 0 clears `busy` and `done` at the next edge and aborts any walk in progress. The signature keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Test mode enable |
| start | input | 1 | Start request, sampled each cycle |
| seq_mode | input | 1 | 1 = sequential order, 0 = alternating complement order |
| blk_sel | input | NUM_BLOCKS | Block select mask |
| seed | input | 160 | Signature seed, loaded on an accepted start |
| host_req | input | 1 | Host read request |
| host_addr | input | AW | Host read address |
| host_gnt | output | 1 | Host request owns the memory port this cycle |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |
| mem_ecc | input | 1 | ECC-detection flag returned with `mem_rdata` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, signature final |
| signature | output | 160 | Current signature register |

## Verification
The assertions assume that the memory answers every read exactly one cycle later and that `host_addr` means something only while `host_req` is high. They also assume `seed` is stable during the cycle in which a start is sampled. The bench follows these rules. Its memory model registers the addressed word on each `mem_re`, and all inputs change one time step after the rising edge. This keeps host preemption, start pulses, mid-walk changes to mode and mask, and test-mode exits well separated from the sampling edge.

// File: rtl/sigchk_pkg.sv
// Package: shared widths and the signature compression step.
// Assumes a fixed 32-bit data word and a 160-bit signature.
package sigchk_pkg;

    localparam int DATA_W = 32;
    localparam int SIG_W  = 160;

    // Feedback constant: bits 159, 158, 157 and 0.
    localparam logic [SIG_W-1:0] SIG_FB = {3'b111, {(SIG_W-4){1'b0}}, 1'b1};

    // One compression step: shift with feedback, then inject data and ECC flag.
    function automatic logic [SIG_W-1:0] misr_next(
        input logic [SIG_W-1:0]  s,
        input logic [DATA_W-1:0] d,
        input logic              e
    );
        logic [SIG_W-1:0] t;
        t = {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? SIG_FB : '0);
        t[DATA_W-1:0] = t[DATA_W-1:0] ^ d;
        t[DATA_W]     = t[DATA_W] ^ e;
        return t;
    endfunction

endpackage

// File: rtl/sigchk_walker.sv
// Address walker: steps through every word of the selected blocks in
// ascending block order, using either the sequential or the alternating
// complement offset order. Mask and mode are captured on an accepted start.
// Assumes BLK_AW >= 2 and that walk_go is only high while run is high.
module sigchk_walker #(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_AW     = 4,
    parameter int SHADOW_BLK = 3,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int AW        = BLK_W + BLK_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_en,
    input  logic                  start_acc,
    input  logic                  seq_mode,
    input  logic [NUM_BLOCKS-1:0] blk_sel,
    input  logic                  walk_go,
    output logic                  run,
    output logic                  seq_q,
    output logic [AW-1:0]         walk_addr,
    output logic                  walk_last,
    output logic                  sel_empty
);

    logic [NUM_BLOCKS-1:0] shadow_oh;
    logic [NUM_BLOCKS-1:0] eff_mask;
    logic [NUM_BLOCKS-1:0] mask_q;
    logic [BLK_W-1:0]      blk_q;
    logic [BLK_AW-1:0]     cnt_q;
    logic [BLK_AW-2:0]     pair;
    logic [BLK_AW-1:0]     off;
    logic [BLK_W:0]        first_hit;
    logic [BLK_W:0]        next_hit;
    logic                  end_of_blk;

    // Reserved block is removed from the mask when the index exists.
    generate
        if (SHADOW_BLK >= 0 && SHADOW_BLK < NUM_BLOCKS) begin : g_shadow
            assign shadow_oh = {{(NUM_BLOCKS-1){1'b0}}, 1'b1} << SHADOW_BLK;
        end else begin : g_noshadow
            assign shadow_oh = '0;
        end
    endgenerate

    // Lowest set mask bit at or above 'from': {found, index}.
    function automatic logic [BLK_W:0] find_from(
        input logic [NUM_BLOCKS-1:0] m,
        input int                    from
    );
        logic [BLK_W:0] r;
        r = '0;
        for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, BLK_W'(i)};
        end
        return r;
    endfunction

    // Walkable blocks and search results.
    always_comb begin
        eff_mask   = blk_sel & ~shadow_oh;
        sel_empty  = ~|eff_mask;
        first_hit  = find_from(eff_mask, 0);
        next_hit   = find_from(mask_q, int'(blk_q) + 1);
        end_of_blk = &cnt_q;
        walk_last  = end_of_blk && !next_hit[BLK_W];
    end

    // Offset order: plain count, or pair index alternating with its complement.
    always_comb begin
        pair = cnt_q[BLK_AW-1:1];
        if (seq_q) off = cnt_q;
        else       off = cnt_q[0] ? {1'b1, ~pair} : {1'b0, pair};
        walk_addr = {blk_q, off};
    end

    // Walk state: capture on start, advance on each issued read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            seq_q  <= 1'b1;
            mask_q <= '0;
            blk_q  <= '0;
            cnt_q  <= '0;
        end else if (!test_en) begin
            run <= 1'b0;
        end else if (start_acc) begin
            run    <= !sel_empty;
            seq_q  <= seq_mode;
            mask_q <= eff_mask;
            blk_q  <= first_hit[BLK_W-1:0];
            cnt_q  <= '0;
        end else if (run && walk_go) begin
            cnt_q <= cnt_q + 1'b1;
            if (end_of_blk) begin
                if (next_hit[BLK_W]) blk_q <= next_hit[BLK_W-1:0];
                else                 run   <= 1'b0;
            end
        end
    end

    AST_WALK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> mask_q[blk_q]); // R2

endmodule

// File: rtl/sigchk_arb.sv
// Port arbiter: sequential walks yield to host reads; alternating walks
// hold the host off. With no walk running the host always owns the port.
// Assumes host_addr is meaningful only while host_req is high.
module sigchk_arb #(
    parameter int AW = 6
) (
    input  logic          host_req,
    input  logic [AW-1:0] host_addr,
    input  logic          run,
    input  logic          seq_q,
    input  logic [AW-1:0] walk_addr,
    output logic          host_gnt,
    output logic          walk_go,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr
);

    // Grant decision and port multiplexer.
    always_comb begin
        host_gnt = host_req && !(run && !seq_q);
        walk_go  = run && !(seq_q && host_req);
        mem_re   = host_gnt || walk_go;
        mem_addr = host_gnt ? host_addr : walk_addr;
    end

endmodule

// File: rtl/sigchk_misr.sv
// Signature register: loads the seed on an accepted start, otherwise
// compresses one returned word per fold strobe and holds in between.
// Assumes load and fold are never high together.
module sigchk_misr
    import sigchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIG_W-1:0]  seed,
    input  logic              fold,
    input  logic [DATA_W-1:0] rdata,
    input  logic              ecc,
    output logic [SIG_W-1:0]  sig
);

    // Seed load or one compression step.
    always_ff @(posedge clk) begin
        if (!rst_n)    sig <= '0;
        else if (load) sig <= seed;
        else if (fold) sig <= misr_next(sig, rdata, ecc);
    end

    AST_SEED_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sig == $past(seed)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !fold |=> $stable(sig)); // R8

endmodule

// File: rtl/flash_sig_walker.sv
// Top: integrity walk over the selected flash blocks with signature
// compression. Reads issued by the walk return one cycle later and are
// folded at that edge; done marks the final compression.
// Assumes a memory with exactly one cycle of read latency.
module flash_sig_walker
    import sigchk_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_AW     = 4,
    parameter int SHADOW_BLK = 3,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int AW        = BLK_W + BLK_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_en,
    input  logic                  start,
    input  logic                  seq_mode,
    input  logic [NUM_BLOCKS-1:0] blk_sel,
    input  logic [SIG_W-1:0]      seed,
    input  logic                  host_req,
    input  logic [AW-1:0]         host_addr,
    output logic                  host_gnt,
    output logic                  mem_re,
    output logic [AW-1:0]         mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_ecc,
    output logic                  busy,
    output logic                  done,
    output logic [SIG_W-1:0]      signature
);

    logic          w_run;
    logic          w_seq;
    logic [AW-1:0] w_addr;
    logic          w_last;
    logic          w_empty;
    logic          walk_go;
    logic          start_acc;
    logic          pend_q;
    logic          pend_last_q;

    // Start gating and busy flag.
    always_comb begin
        busy      = w_run || pend_q;
        start_acc = start && test_en && !busy;
    end

    sigchk_walker #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_AW     (BLK_AW),
        .SHADOW_BLK (SHADOW_BLK)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .start_acc (start_acc),
        .seq_mode  (seq_mode),
        .blk_sel   (blk_sel),
        .walk_go   (walk_go),
        .run       (w_run),
        .seq_q     (w_seq),
        .walk_addr (w_addr),
        .walk_last (w_last),
        .sel_empty (w_empty)
    );

    sigchk_arb #(
        .AW (AW)
    ) u_arb (
        .host_req  (host_req),
        .host_addr (host_addr),
        .run       (w_run),
        .seq_q     (w_seq),
        .walk_addr (w_addr),
        .host_gnt  (host_gnt),
        .walk_go   (walk_go),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr)
    );

    // Track the outstanding walk read and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_en) begin
            pend_q      <= 1'b0;
            pend_last_q <= 1'b0;
            done        <= 1'b0;
        end else begin
            pend_q      <= walk_go;
            pend_last_q <= walk_go && w_last;
            if (start_acc)        done <= w_empty;
            else if (pend_last_q) done <= 1'b1;
        end
    end

    sigchk_misr u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_acc),
        .seed  (seed),
        .fold  (pend_q && test_en),
        .rdata (mem_rdata),
        .ecc   (mem_ecc),
        .sig   (signature)
    );

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en && start && !busy |=> !busy); // R1
    AST_SHADOW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re && !host_gnt |-> int'(mem_addr[AW-1:BLK_AW]) != SHADOW_BLK); // R3
    AST_HOST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> mem_re && mem_addr == host_addr); // R6
    AST_ALT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        w_run && !w_seq |-> !host_gnt); // R7
    AST_DONE_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(done) && !$past(start) |-> $stable(signature)); // R8
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_TESTMODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !busy && !done); // R13

endmodule

// File: tb/flash_sig_walker_test.sv
`timescale 1ns/1ps
module flash_sig_walker_test;

    localparam int NB = 4;
    localparam int BAW = 4;
    localparam int W = 1 << BAW;
    localparam int AW = 6;
    localparam int SHB = 3;
    localparam logic [159:0] FBK = (160'h7 << 157) | 160'h1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic          start = 1'b0;
    logic          seq_mode = 1'b1;
    logic [NB-1:0] blk_sel = '0;
    logic [159:0]  seed = '0;
    logic          host_req = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_gnt, mem_re, busy, done;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          mem_ecc;
    logic [159:0]  signature;

    logic [31:0]   mem [64];
    logic          ecm [64];

    integer n_cmp = 0;
    integer n_bad = 0;
    integer shadow_hits = 0;

    // reference model state
    logic          m_run = 1'b0, m_seq = 1'b1, m_pend = 1'b0, m_last = 1'b0, m_done = 1'b0;
    logic [159:0]  m_sig = '0;
    int            m_q[$];
    int            m_paddr = 0;

    always #2 clk = ~clk;

    flash_sig_walker uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
        .seq_mode(seq_mode), .blk_sel(blk_sel), .seed(seed),
        .host_req(host_req), .host_addr(host_addr), .host_gnt(host_gnt),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ecc(mem_ecc), .busy(busy), .done(done), .signature(signature)
    );

    // memory model with one cycle read latency
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem[mem_addr];
            mem_ecc   <= ecm[mem_addr];
        end
    end

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [159:0] ref_fold(input logic [159:0] s, input logic [31:0] d, input logic e);
        logic top;
        top = s[159];
        s = s << 1;
        if (top) s = s ^ FBK;
        s[31:0] = s[31:0] ^ d;
        s[32] = s[32] ^ e;
        return s;
    endfunction

    // cycle-by-cycle comparison and model advance
    always @(negedge clk) begin
        logic go, gnt, bz;
        int   wa;
        if (!rst_n) begin
            m_run = 0; m_pend = 0; m_last = 0; m_done = 0; m_sig = '0; m_q.delete();
        end else begin
            wa  = (m_q.size() > 0) ? m_q[0] : 0;
            go  = m_run && !(m_seq && host_req);
            gnt = host_req && !(m_run && !m_seq);
            bz  = m_run || m_pend;
            chk(m_seq ? "R6 host_gnt" : "R7 host_gnt", host_gnt, gnt);
            chk("R2 mem_re", mem_re, gnt || go);
            if (gnt) chk("R6 mem_addr host", mem_addr, host_addr);
            else if (go) chk(m_seq ? "R4 mem_addr walk" : "R5 mem_addr walk", mem_addr, wa);
            chk("R10 busy", busy, bz);
            chk("R10 done", done, m_done);
            chk("R9 signature", signature, m_sig);
            if (mem_re && !host_gnt && mem_addr[5:4] == 2'(SHB)) shadow_hits++;
            if (!test_en) begin
                m_run = 0; m_pend = 0; m_last = 0; m_done = 0; m_q.delete();
            end else begin
                if (m_pend) begin
                    m_sig = ref_fold(m_sig, mem[m_paddr], ecm[m_paddr]);
                    if (m_last) m_done = 1;
                end
                m_pend = go;
                m_last = 0;
                if (go) begin
                    m_paddr = m_q[0];
                    m_last = (m_q.size() == 1);
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_run = 0;
                end
                if (start && !bz) begin
                    m_sig = seed;
                    m_seq = seq_mode;
                    m_q.delete();
                    for (int b = 0; b < NB; b++) begin
                        if (blk_sel[b] && b != SHB) begin
                            for (int p = 0; p < W / 2; p++) begin
                                if (seq_mode) begin
                                    m_q.push_back(b * W + 2 * p);
                                    m_q.push_back(b * W + 2 * p + 1);
                                end else begin
                                    m_q.push_back(b * W + p);
                                    m_q.push_back(b * W + (W - 1 - p));
                                end
                            end
                        end
                    end
                    m_run = (m_q.size() > 0);
                    m_done = (m_q.size() == 0);
                end
            end
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic pulse_start(input logic [159:0] sd);
        @(posedge clk); #1;
        seed = sd; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // host pattern: 0 none, 1 every third cycle, 2 always
    task automatic run_until_done(input int hp);
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #1;
            host_req  = (hp == 2) || (hp == 1 && (k % 3) == 1);
            host_addr = AW'(k * 7 + 5);
            if (done) break;
        end
        host_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [159:0] sig_a;
        for (int i = 0; i < 64; i++) begin
            mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5AC3C3;
            ecm[i] = ((i % 5) == 2);
        end
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R8 reset signature", signature, 0);

        // R1: start outside test mode
        blk_sel = 4'b0011;
        pulse_start(160'hABCD);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy stays low", busy, 0);
        chk("R1 signature unchanged", signature, 0);

        // R4 R9: sequential walk of blocks 0 and 2
        test_en = 1'b1;
        seq_mode = 1'b1; blk_sel = 4'b0101;
        pulse_start({5{32'h1234_5678}});
        run_until_done(0);
        chk("R10 done after seq walk", done, 1);
        chk("R9 final signature", signature, m_sig);

        // R3 R6: all blocks selected incl. shadow, host preempts
        shadow_hits = 0;
        blk_sel = 4'b1111;
        pulse_start({160{1'b1}});
        run_until_done(1);
        chk("R3 shadow never read", shadow_hits, 0);
        chk("R6 signature after preemption", signature, m_sig);

        // R5 R7: alternating walk with host asserting throughout
        seq_mode = 1'b0; blk_sel = 4'b0110;
        pulse_start(160'h0F0F_0000_1111);
        run_until_done(2);
        chk("R7 alt signature", signature, m_sig);

        // R11 R12: change mode/mask mid walk, restart while busy
        seq_mode = 1'b0; blk_sel = 4'b0011;
        pulse_start(160'h77);
        repeat (4) @(posedge clk); #1;
        seq_mode = 1'b1; blk_sel = 4'b0100;
        pulse_start(160'hDEAD);
        run_until_done(0);
        chk("R11 captured settings", signature, m_sig);
        chk("R12 restart ignored", (signature == 160'hDEAD), 0);

        // R10: only shadow selected: empty walk
        blk_sel = 4'b1000;
        pulse_start(160'h55);
        @(negedge clk);
        chk("R10 empty done", done, 1);
        chk("R10 empty busy", busy, 0);
        chk("R8 empty seed", signature, 160'h55);

        // R9: corrupted ECC flag changes signature
        seq_mode = 1'b1; blk_sel = 4'b0001;
        pulse_start(160'h9);
        run_until_done(0);
        sig_a = signature;
        ecm[5] = ~ecm[5];
        pulse_start(160'h9);
        run_until_done(0);
        chk("R9 corruption detected", (signature == sig_a), 0);
        ecm[5] = ~ecm[5];

        // R13: leave test mode mid walk
        blk_sel = 4'b0111;
        pulse_start(160'h3);
        repeat (6) @(posedge clk); #1;
        test_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R13 busy cleared", busy, 0);
        chk("R13 done cleared", done, 0);
        @(posedge clk); #1;
        test_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule